// File: doc/BRIEF.md
# Deferred Register Write-Back Buffer

This block holds back the register updates produced while an instruction packet executes, and only lets them reach the architectural state when the packet commits. Until then every read port returns the values from before the packet. Two instructions issued side by side in one packet can therefore read their operands without seeing each other's results. The block owns sixteen 16-bit general registers and two 40-bit accumulators. Each update is queued as an entry that holds a target, a keep-mask and a data value. At commit the entries are merged into their targets one after another, in the order they were queued.

The execution stage requests an update on the pend port and ends the packet with either a commit strobe or a discard strobe. A discard throws away every queued update at once, so a packet changes the registers completely or not at all. The sequencer has two states. ST_IDLE accepts pend, commit and discard requests. ST_DRAIN applies one entry per clock. The transition IDLE→DRAIN happens on a commit when the queue is not empty and no discard is present. The transition DRAIN→IDLE happens once the last queued entry has been applied, and that same edge empties the queue. Every other case holds the current state.

Top module: `wb_defer_buf`

## Requirements
- R1: After reset the block is in the following state. All sixteen general registers read 0. Both accumulators read 0. The queue count is 0. The overflow flag is 0 and busy is 0.
- R2: pend_kind selects the kind of update. Code 0 writes one general register, code 1 writes an accumulator, code 2 writes a register pair, and code 3 requests nothing. An accepted pend raises q_count by the number of entries it creates. Read ports never return queued values before commit. A code 3 request changes neither q_count nor overflow.
- R3: On a commit with n>0 entries queued, busy is high for exactly n cycles. Entries are applied in queue order, one per cycle, so a later entry to the same target overrides an earlier one. When busy falls, q_count is 0.
- R4: Each commit turns the target into (old AND keep) OR data. A general register uses bits 15:0 of pend_keep and pend_val. A keep of zero overwrites the whole target.
- R5: Discard in ST_IDLE empties the queue on the next edge, clears overflow and leaves every register unchanged.
- R6: An accumulator write uses only bits 39:0 of pend_val and pend_keep. Bit 0 of pend_idx selects the accumulator.
- R7: A pair write to index N queues two entries, which take two queue slots. The first sends bits 31:16 to register N. The second sends bits 15:0 to register (N+1) mod 16. The keep bits are split in the same way.
- R8: The pair read port returns register N in bits 31:16 and register (N+1) mod 16 in bits 15:0.
- R9: A pend request is dropped whole if the queue lacks room for all of its entries. For example, a pair write with only one free slot is dropped. A dropped pend sets overflow. overflow stays set until a commit or discard in ST_IDLE. q_count never exceeds DEPTH (16).
- R10: In ST_DRAIN, pend, commit and discard are ignored. A pend presented in the same cycle as a commit or discard is also dropped, and it does not set overflow.
- R11: A commit with an empty queue stays in ST_IDLE and clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid | input | 1 | Update request this cycle |
| pend_kind | input | 2 | 0 general, 1 accumulator, 2 pair, 3 none |
| pend_idx | input | 4 | Target register index (bit 0 picks the accumulator) |
| pend_keep | input | 64 | Keep-mask: bits of the old value that survive |
| pend_val | input | 64 | Data value ORed into the target |
| commit | input | 1 | Apply all queued entries |
| discard | input | 1 | Drop all queued entries |
| busy | output | 1 | High while entries are being applied |
| q_count | output | 5 | Number of queued entries |
| overflow | output | 1 | Sticky flag set by a dropped pend request |
| gpr_rd_idx | input | 4 | General register read index |
| gpr_rd_val | output | 16 | Committed general register value |
| pair_rd_idx | input | 4 | Pair read base index N |
| pair_rd_val | output | 32 | {reg N, reg N+1} |
| acc_rd_sel | input | 1 | Accumulator read select |
| acc_rd_val | output | 40 | Committed accumulator value |

## Verification
The assertions assume a synchronous reset that is held across the first clock edge. They also assume that read indices change only when the bench intends to read, because the read-stability property pairs a stable index with a stable value in cycles where no entry was applied. The bench keeps to this. It drives every input just after a rising edge and holds the read indices fixed while the queue fills. Strobes presented during a drain are deliberate: the bench raises them on purpose to show that they are ignored, and it drops them in the first cycle after busy falls.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    localparam int GPR_W     = 16;
    localparam int ACC_W     = 40;
    localparam int GPR_CNT   = 16;
    localparam int ACC_CNT   = 2;
    localparam int IN_W      = 64;
    localparam int IDX_W     = $clog2(GPR_CNT);
    localparam int ACC_SEL_W = $clog2(ACC_CNT);

    typedef enum logic [1:0] {
        KIND_GPR  = 2'd0,
        KIND_ACC  = 2'd1,
        KIND_PAIR = 2'd2,
        KIND_NONE = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic             to_acc;
        logic [IDX_W-1:0] idx;
        logic [ACC_W-1:0] keep;
        logic [ACC_W-1:0] val;
    } wb_entry_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wbq_queue.sv
module wbq_queue
    import wbq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [1:0]       need,
    input  wb_entry_t        ent_a,
    input  wb_entry_t        ent_b,
    input  logic             clear,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output wb_entry_t        rd_ent,
    output logic             ovf_set
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   room;
    logic             fits;
    logic             push;
    wb_entry_t        slot_q [DEPTH];

    // Room check covers every entry of the request, so a pair is all or nothing.
    always_comb begin
        room    = (CNT_W+1)'(DEPTH) - {1'b0, count_q};
        fits    = (CNT_W+1)'(need) <= room;
        push    = push_req && fits;
        ovf_set = push_req && !fits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clear)   count_q <= '0;
        else if (push)    count_q <= count_q + CNT_W'(need);
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic      wr_a;
        logic      wr_b;
        wb_entry_t ent_q;
        assign wr_a = push && (count_q == CNT_W'(s));
        assign wr_b = push && (need == 2'd2) && ((count_q + 1'b1) == CNT_W'(s));
        always_ff @(posedge clk) begin
            if (!rst_n)     ent_q <= '0;
            else if (wr_a)  ent_q <= ent_a;
            else if (wr_b)  ent_q <= ent_b;
        end
        assign slot_q[s] = ent_q;
    end

    assign count  = count_q;
    assign rd_ent = slot_q[rd_ptr];
endmodule

// File: rtl/wbq_regfile.sv
module wbq_regfile
    import wbq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply_en,
    input  wb_entry_t          apply_ent,
    input  logic [IDX_W-1:0]   gpr_rd_idx,
    input  logic [IDX_W-1:0]   pair_rd_idx,
    input  logic               acc_rd_sel,
    output logic [GPR_W-1:0]   gpr_rd_val,
    output logic [2*GPR_W-1:0] pair_rd_val,
    output logic [ACC_W-1:0]   acc_rd_val
);
    logic [GPR_W-1:0] gpr_q [GPR_CNT];
    logic [ACC_W-1:0] acc_q [ACC_CNT];
    logic [IDX_W-1:0] pair_lo_idx;

    for (genvar g = 0; g < GPR_CNT; g++) begin : g_gpr
        logic             hit;
        logic [GPR_W-1:0] r_q;
        assign hit = apply_en && !apply_ent.to_acc && (apply_ent.idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)    r_q <= '0;
            else if (hit)  r_q <= (r_q & apply_ent.keep[GPR_W-1:0]) | apply_ent.val[GPR_W-1:0];
        end
        assign gpr_q[g] = r_q;
    end

    for (genvar a = 0; a < ACC_CNT; a++) begin : g_acc
        logic             hit;
        logic [ACC_W-1:0] r_q;
        assign hit = apply_en && apply_ent.to_acc &&
                     (apply_ent.idx[ACC_SEL_W-1:0] == ACC_SEL_W'(a));
        always_ff @(posedge clk) begin
            if (!rst_n)    r_q <= '0;
            else if (hit)  r_q <= (r_q & apply_ent.keep) | apply_ent.val;
        end
        assign acc_q[a] = r_q;
    end

    always_comb begin
        pair_lo_idx = pair_rd_idx + 1'b1;
        gpr_rd_val  = gpr_q[gpr_rd_idx];
        pair_rd_val = {gpr_q[pair_rd_idx], gpr_q[pair_lo_idx]};
        acc_rd_val  = acc_q[acc_rd_sel];
    end
endmodule

// File: rtl/wbq_seq.sv
module wbq_seq
    import wbq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             discard,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             apply_en,
    output logic [PTR_W-1:0] apply_ptr,
    output logic             q_clear,
    output logic             accept_ok,
    output logic             ovf_clear
);
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] last_pos;
    logic             at_last;

    assign last_pos = count - 1'b1;
    assign at_last  = (ptr_q == last_pos[PTR_W-1:0]);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!discard && commit && (count != '0)) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (at_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= (state_q == ST_DRAIN) ? ptr_q + 1'b1 : '0;
        end
    end

    always_comb begin
        busy      = 1'b0;
        apply_en  = 1'b0;
        q_clear   = 1'b0;
        accept_ok = 1'b0;
        ovf_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept_ok = !commit && !discard;
                ovf_clear = commit || discard;
                q_clear   = discard;
            end
            ST_DRAIN: begin
                busy     = 1'b1;
                apply_en = 1'b1;
                q_clear  = at_last;
            end
            default: ;
        endcase
    end

    assign apply_ptr = ptr_q;
endmodule

// File: rtl/wb_defer_buf.sv
module wb_defer_buf
    import wbq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pend_valid,
    input  logic [1:0]         pend_kind,
    input  logic [IDX_W-1:0]   pend_idx,
    input  logic [IN_W-1:0]    pend_keep,
    input  logic [IN_W-1:0]    pend_val,
    input  logic               commit,
    input  logic               discard,
    output logic               busy,
    output logic [CNT_W-1:0]   q_count,
    output logic               overflow,
    input  logic [IDX_W-1:0]   gpr_rd_idx,
    output logic [GPR_W-1:0]   gpr_rd_val,
    input  logic [IDX_W-1:0]   pair_rd_idx,
    output logic [2*GPR_W-1:0] pair_rd_val,
    input  logic               acc_rd_sel,
    output logic [ACC_W-1:0]   acc_rd_val
);
    wb_entry_t        ent_a;
    wb_entry_t        ent_b;
    wb_entry_t        apply_ent;
    logic [1:0]       need;
    logic             push_req;
    logic             accept_ok;
    logic             q_clear;
    logic             ovf_set;
    logic             ovf_clear;
    logic             apply_en;
    logic [PTR_W-1:0] apply_ptr;
    logic             ovf_q;

    // Shape the request into one or two queue entries.
    always_comb begin
        ent_a = '0;
        ent_b = '0;
        need  = 2'd0;
        unique case (wr_kind_e'(pend_kind))
            KIND_GPR: begin
                ent_a.idx  = pend_idx;
                ent_a.keep = ACC_W'(pend_keep[GPR_W-1:0]);
                ent_a.val  = ACC_W'(pend_val[GPR_W-1:0]);
                need       = 2'd1;
            end
            KIND_ACC: begin
                ent_a.to_acc = 1'b1;
                ent_a.idx    = IDX_W'(pend_idx[ACC_SEL_W-1:0]);
                ent_a.keep   = pend_keep[ACC_W-1:0];
                ent_a.val    = pend_val[ACC_W-1:0];
                need         = 2'd1;
            end
            KIND_PAIR: begin
                ent_a.idx  = pend_idx;
                ent_a.keep = ACC_W'(pend_keep[2*GPR_W-1:GPR_W]);
                ent_a.val  = ACC_W'(pend_val[2*GPR_W-1:GPR_W]);
                ent_b.idx  = pend_idx + 1'b1;
                ent_b.keep = ACC_W'(pend_keep[GPR_W-1:0]);
                ent_b.val  = ACC_W'(pend_val[GPR_W-1:0]);
                need       = 2'd2;
            end
            KIND_NONE: need = 2'd0;
            default:   need = 2'd0;
        endcase
    end

    assign push_req = pend_valid && accept_ok && (need != 2'd0);

    wbq_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .discard   (discard),
        .count     (q_count),
        .busy      (busy),
        .apply_en  (apply_en),
        .apply_ptr (apply_ptr),
        .q_clear   (q_clear),
        .accept_ok (accept_ok),
        .ovf_clear (ovf_clear)
    );

    wbq_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .need     (need),
        .ent_a    (ent_a),
        .ent_b    (ent_b),
        .clear    (q_clear),
        .rd_ptr   (apply_ptr),
        .count    (q_count),
        .rd_ent   (apply_ent),
        .ovf_set  (ovf_set)
    );

    wbq_regfile u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply_en    (apply_en),
        .apply_ent   (apply_ent),
        .gpr_rd_idx  (gpr_rd_idx),
        .pair_rd_idx (pair_rd_idx),
        .acc_rd_sel  (acc_rd_sel),
        .gpr_rd_val  (gpr_rd_val),
        .pair_rd_val (pair_rd_val),
        .acc_rd_val  (acc_rd_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_q <= 1'b0;
        else if (ovf_clear)  ovf_q <= 1'b0;
        else if (ovf_set)    ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/wbq_chk.sv
module wbq_chk #(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [CNT_W-1:0] q_count,
    input logic             overflow,
    input logic             commit,
    input logic             discard,
    input logic [3:0]       gpr_rd_idx,
    input logic [15:0]      gpr_rd_val
);
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !commit && !discard |=> overflow);

    // R5
    discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && discard |=> (q_count == '0) && !overflow && !busy);

    // R3
    drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (q_count == '0));

    // R2
    no_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) && $stable(gpr_rd_idx) |-> $stable(gpr_rd_val));

    // R10
    drain_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(overflow) && ((q_count == $past(q_count)) || (q_count == '0)));

    // R11
    empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && commit && !discard && (q_count == '0) |=> !busy && !overflow);
endmodule

bind wb_defer_buf wbq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .q_count    (q_count),
    .overflow   (overflow),
    .commit     (commit),
    .discard    (discard),
    .gpr_rd_idx (gpr_rd_idx),
    .gpr_rd_val (gpr_rd_val)
);

// File: tb/wb_defer_buf_tb.sv
module wb_defer_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pend_valid;
    logic [1:0]  pend_kind;
    logic [3:0]  pend_idx;
    logic [63:0] pend_keep;
    logic [63:0] pend_val;
    logic        commit;
    logic        discard;
    logic        busy;
    logic [4:0]  q_count;
    logic        overflow;
    logic [3:0]  gpr_rd_idx;
    logic [15:0] gpr_rd_val;
    logic [3:0]  pair_rd_idx;
    logic [31:0] pair_rd_val;
    logic        acc_rd_sel;
    logic [39:0] acc_rd_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model of the architectural state and queue, built from the requirements
    logic [15:0] m_gpr [16];
    logic [39:0] m_acc [2];
    bit          q_acc  [16];
    int          q_idx  [16];
    logic [39:0] q_keep [16];
    logic [39:0] q_val  [16];
    int          q_n;
    bit          m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_defer_buf u_dut (
        .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_kind(pend_kind),
        .pend_idx(pend_idx), .pend_keep(pend_keep), .pend_val(pend_val),
        .commit(commit), .discard(discard), .busy(busy), .q_count(q_count),
        .overflow(overflow), .gpr_rd_idx(gpr_rd_idx), .gpr_rd_val(gpr_rd_val),
        .pair_rd_idx(pair_rd_idx), .pair_rd_val(pair_rd_val),
        .acc_rd_sel(acc_rd_sel), .acc_rd_val(acc_rd_val)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_pend(input int kind, input int idx, input logic [63:0] keep, input logic [63:0] val);
        int need;
        need = (kind == 0 || kind == 1) ? 1 : (kind == 2 ? 2 : 0);
        if (need == 0) return;
        if (q_n + need > 16) begin
            m_ovf = 1;
            return;
        end
        if (kind == 0) begin
            q_acc[q_n] = 0; q_idx[q_n] = idx;
            q_keep[q_n] = {24'h0, keep[15:0]}; q_val[q_n] = {24'h0, val[15:0]};
            q_n++;
        end else if (kind == 1) begin
            q_acc[q_n] = 1; q_idx[q_n] = idx % 2;
            q_keep[q_n] = keep[39:0]; q_val[q_n] = val[39:0];
            q_n++;
        end else begin
            q_acc[q_n] = 0; q_idx[q_n] = idx;
            q_keep[q_n] = {24'h0, keep[31:16]}; q_val[q_n] = {24'h0, val[31:16]};
            q_n++;
            q_acc[q_n] = 0; q_idx[q_n] = (idx + 1) % 16;
            q_keep[q_n] = {24'h0, keep[15:0]}; q_val[q_n] = {24'h0, val[15:0]};
            q_n++;
        end
    endtask

    task automatic model_commit();
        for (int e = 0; e < q_n; e++) begin
            if (q_acc[e]) m_acc[q_idx[e]] = (m_acc[q_idx[e]] & q_keep[e]) | q_val[e];
            else          m_gpr[q_idx[e]] = (m_gpr[q_idx[e]] & q_keep[e][15:0]) | q_val[e][15:0];
        end
        q_n = 0;
        m_ovf = 0;
    endtask

    task automatic pend(input int kind, input int idx, input logic [63:0] keep, input logic [63:0] val);
        pend_valid = 1; pend_kind = 2'(kind); pend_idx = 4'(idx);
        pend_keep = keep; pend_val = val;
        tick();
        pend_valid = 0;
        model_pend(kind, idx, keep, val);
    endtask

    // noisy=1 presents a pend with the commit and strobes everything during the drain (R10)
    task automatic commit_wait(input string tag, input bit noisy);
        int n;
        int cyc;
        n = q_n;
        commit = 1;
        if (noisy) begin
            pend_valid = 1; pend_kind = 2'd0; pend_idx = 4'd9;
            pend_keep = 64'h0; pend_val = 64'hFFFF;
        end
        tick();
        commit = 0;
        cyc = 0;
        while (busy && cyc < 100) begin
            if (noisy) begin commit = 1; discard = 1; pend_valid = 1; end
            cyc++;
            tick();
        end
        commit = 0; discard = 0; pend_valid = 0;
        model_commit();
        chk(cyc == n, {tag, " busy cycles"}, 64'(cyc), 64'(n));
        chk(q_count == 0, {tag, " count after drain"}, 64'(q_count), 64'd0);
        chk(overflow == 0, {tag, " overflow after commit"}, 64'(overflow), 64'd0);
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < 16; r++) begin
            gpr_rd_idx = 4'(r);
            #1;
            chk(gpr_rd_val == m_gpr[r], $sformatf("%s gpr%0d", tag, r), 64'(gpr_rd_val), 64'(m_gpr[r]));
        end
        for (int a = 0; a < 2; a++) begin
            acc_rd_sel = 1'(a);
            #1;
            chk(acc_rd_val == m_acc[a], $sformatf("%s acc%0d", tag, a), 64'(acc_rd_val), 64'(m_acc[a]));
        end
        gpr_rd_idx = 0; acc_rd_sel = 0;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WDOG_LIMIT, WDOG_LIMIT);
        report();
    end

    initial begin
        logic [63:0] v;
        logic [63:0] k;
        rst_n = 0; pend_valid = 0; pend_kind = 0; pend_idx = 0; pend_keep = 0; pend_val = 0;
        commit = 0; discard = 0; gpr_rd_idx = 0; pair_rd_idx = 0; acc_rd_sel = 0;
        for (int r = 0; r < 16; r++) m_gpr[r] = 0;
        m_acc[0] = 0; m_acc[1] = 0; q_n = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        check_all("R1 reset");
        chk(q_count == 0, "R1 count", 64'(q_count), 64'd0);
        chk(busy == 0, "R1 busy", 64'(busy), 64'd0);
        chk(overflow == 0, "R1 overflow", 64'(overflow), 64'd0);

        // R2/R3/R4 full sweep over every general register, keep upper bits must not matter
        for (int i = 0; i < 16; i++) begin
            v = 64'hDEAD_BEEF_CAFE_0000 | 64'(16'(i * 16'h1357 + 16'h0101));
            pend(0, i, 64'hFFFF_FFFF_FFFF_0000, v);
        end
        chk(q_count == 16, "R2 count after 16 pends", 64'(q_count), 64'd16);
        check_all("R2 no forwarding before commit");
        commit_wait("R3 sweep", 0);
        check_all("R4 plain overwrite");

        // R4 merge patterns
        for (int i = 0; i < 8; i++) begin
            k = 64'(16'((16'h0F0F << i) ^ (i * 16'h1111)));
            v = 64'(16'(i * 16'h0203));
            pend(0, i + 2, k, v);
        end
        commit_wait("R4 merge", 0);
        check_all("R4 merge");

        // R3 queue order, later entry wins
        pend(0, 5, 0, 64'h1111);
        pend(0, 5, 0, 64'h2222);
        pend(0, 6, 0, 64'h00F0);
        pend(0, 6, 64'hFF0F, 64'h0001);
        commit_wait("R3 order", 0);
        gpr_rd_idx = 5; #1;
        chk(gpr_rd_val == 16'h2222, "R3 later wins", 64'(gpr_rd_val), 64'h2222);
        gpr_rd_idx = 6; #1;
        chk(gpr_rd_val == 16'h0001, "R3 applied in order", 64'(gpr_rd_val), 64'h0001);

        // R7 pair writes for every base index, including the wrap from 15 to 0
        for (int n = 0; n < 16; n++) begin
            v = 64'hFFFF_0000_0000_0000 | 64'(32'(32'hA000_5000 + n * 32'h0101_1010));
            k = (n % 2 == 1) ? 64'h00FF_FF00 : 64'h0;
            pend(2, n, k, v);
            chk(q_count == 2, "R7 pair takes two slots", 64'(q_count), 64'd2);
            commit_wait("R7 pair", 0);
            gpr_rd_idx = 4'(n); #1;
            chk(gpr_rd_val == m_gpr[n], "R7 pair upper half", 64'(gpr_rd_val), 64'(m_gpr[n]));
            gpr_rd_idx = 4'((n + 1) % 16); #1;
            chk(gpr_rd_val == m_gpr[(n + 1) % 16], "R7 pair lower half", 64'(gpr_rd_val), 64'(m_gpr[(n + 1) % 16]));
        end
        // R8 pair read sweep
        for (int n = 0; n < 16; n++) begin
            pair_rd_idx = 4'(n); #1;
            chk(pair_rd_val == {m_gpr[n], m_gpr[(n + 1) % 16]}, "R8 pair read",
                64'(pair_rd_val), 64'({m_gpr[n], m_gpr[(n + 1) % 16]}));
        end

        // R6 accumulator truncation and select
        pend(1, 0, 0, 64'hFFFF_FF12_3456_789A);
        pend(1, 3, 0, 64'h1234_5600_0000_0001);
        commit_wait("R6 acc write", 0);
        check_all("R6 acc truncation");
        pend(1, 1, 64'hFFFF_FF00_0000_FFFF, 64'h00AB_0000_00CD_0000);
        commit_wait("R6 acc merge", 0);
        check_all("R6 acc merge");

        // R5 discard
        pend(0, 1, 0, 64'h5555);
        pend(1, 0, 0, 64'h77);
        pend(2, 8, 0, 64'h1234_5678);
        chk(q_count == 4, "R5 count before discard", 64'(q_count), 64'd4);
        discard = 1; tick(); discard = 0;
        q_n = 0; m_ovf = 0;
        chk(q_count == 0, "R5 count after discard", 64'(q_count), 64'd0);
        commit_wait("R5 commit after discard", 0);
        check_all("R5 registers unchanged");

        // R9 overflow with single entries
        for (int i = 0; i < 16; i++) pend(0, 7, 0, 64'(16'h0700 + i));
        pend(0, 7, 0, 64'h0BAD);
        chk(overflow == 1, "R9 overflow set", 64'(overflow), 64'd1);
        chk(q_count == 16, "R9 count held at depth", 64'(q_count), 64'd16);
        pend(3, 0, 0, 0);
        chk(overflow == 1, "R9 overflow sticky", 64'(overflow), 64'd1);
        commit_wait("R9 commit clears", 0);
        check_all("R9 dropped entry not applied");

        // R9 pair with one slot left is dropped whole
        for (int i = 0; i < 15; i++) pend(0, 12, 0, 64'(16'h0C00 + i));
        pend(2, 3, 0, 64'h9999_8888);
        chk(q_count == 15, "R9 pair dropped count", 64'(q_count), 64'd15);
        chk(overflow == 1, "R9 pair dropped overflow", 64'(overflow), 64'd1);
        discard = 1; tick(); discard = 0;
        q_n = 0; m_ovf = 0;
        chk(overflow == 0, "R5 discard clears overflow", 64'(overflow), 64'd0);
        check_all("R9 after pair drop");

        // R2 code 3 requests nothing
        pend(3, 4, 0, 64'h4444);
        chk(q_count == 0, "R2 code 3 count", 64'(q_count), 64'd0);
        chk(overflow == 0, "R2 code 3 overflow", 64'(overflow), 64'd0);

        // R10 pend alongside commit, and strobes during the drain
        pend(0, 10, 0, 64'hA0A0);
        pend(1, 1, 0, 64'h33_0000_0003);
        pend(0, 11, 0, 64'hB1B1);
        commit_wait("R10 noisy drain", 1);
        check_all("R10 strobes ignored");

        // R11 commit on empty queue
        commit = 1; tick(); commit = 0;
        chk(busy == 0, "R11 empty commit busy", 64'(busy), 64'd0);
        chk(q_count == 0, "R11 empty commit count", 64'(q_count), 64'd0);
        check_all("R11 registers unchanged");

        report();
    end
endmodule